// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of week, day of month, month, two-digit year and two-digit century, so any date from year 0000 to 9999 can be held. A 32.768 kHz clock enable feeds a prescaler that produces one step per second. Each step ripples through the fields in a single cycle, using the month length and the leap-year rule of the current year.

A host loads any calendar time through a register write port and reads registers through a combinational read port. A control register can stop counting. It can also freeze a copy of all eight time registers, so that a read spread over several cycles sees one coherent time while the live counter keeps running.

Both host ports are plain register ports with no valid/ready pair. A write is taken on every cycle in which the write enable is high, and a read address is answered in the same cycle. The host is therefore never stalled and there is no back-pressure.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Reset loads the time 00:00:00, day of week 01, date 01, month 01, year 00 and century 20. It also sets the control register to run=1 and hold=0.
- R2: While run is 1, the time advances by exactly one second on every TICKS_PER_SEC-th cycle that has tick_en high. Cycles with tick_en low do not count.
- R3: Seconds and minutes roll from 59 to 00, and each roll carries into the next field. Hours roll from 23 to 00 and carry into the day fields.
- R4: On each day carry, day of week goes up by one, and from 07 it returns to 01.
- R5: On each day carry, the date returns from the month's last day to 01 and the month goes up by one. April, June, September and November end on 30, February ends on 28 (29 in a leap year), and all other months end on 31.
- R6: A leap year is one whose full year (century×100 + year) divides by 4, except century years that do not divide by 400.
- R7: Month 12 rolls to 01 and carries into the year. Year 99 rolls to 00 and carries into the century. Century 99 rolls to 00.
- R8: The register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year and 7 century. A write to any of them stores wr_data there and restarts the prescaler, so the next step comes a full second later. A step that falls in the same cycle as such a write is dropped.
- R9: Address 8 is the control register, with bit 0 = run and bit 1 = hold, and it reads back as {6'b0, hold, run}. While run is 0, the prescaler and the time do not move.
- R10: While hold is 1, reads of addresses 0–7 return the values the live registers had on the cycle the hold was written, and the live time keeps counting. Clearing hold makes the live values readable again.
- R11: rd_data follows rd_addr in the same cycle, and addresses 9–15 read as 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz oscillator rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data (BCD for time fields) |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4, so one second lasts only a few enabled cycles. At that setting the timing of the prescaler restart and of a step dropped by a coincident write can be checked against exact cycles. Each calendar boundary is reached by loading the time just before it, with the one-second step following soon after. The boundaries covered are the leap and non-leap ends of February, the ends of 30-day and 31-day months, the end of a year and the century wrap at 9999. Irregular tick_en patterns run against the behavioural model check that only enabled cycles count. The default of 32768 is only elaborated.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned REG_ADDR_W = 4;
  localparam logic [REG_ADDR_W-1:0] CTRL_ADDR = 4'd8;

  localparam int unsigned FLD_SEC   = 0;
  localparam int unsigned FLD_MIN   = 1;
  localparam int unsigned FLD_HOUR  = 2;
  localparam int unsigned FLD_WDAY  = 3;
  localparam int unsigned FLD_DATE  = 4;
  localparam int unsigned FLD_MONTH = 5;
  localparam int unsigned FLD_YEAR  = 6;
  localparam int unsigned FLD_CENT  = 7;

  typedef logic [7:0] bcd8_t;

  // Two-digit BCD increment (caller handles the wrap).
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    bcd8_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Value modulo 4 of a BCD pair: tens*10 mod 4 equals 2*tens[0].
  function automatic logic [1:0] bcd_mod4(input bcd8_t v);
    return {v[4], 1'b0} + v[1:0];
  endfunction

  function automatic logic is_leap(input bcd8_t cent, input bcd8_t yr);
    logic r;
    if (yr == 8'h00) r = (bcd_mod4(cent) == 2'd0);
    else             r = (bcd_mod4(yr) == 2'd0);
    return r;
  endfunction

  function automatic bcd8_t month_last_day(input bcd8_t mon, input logic leap);
    bcd8_t r;
    case (mon)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic bcd8_t field_reset(input int unsigned f);
    bcd8_t r;
    case (f)
      FLD_WDAY, FLD_DATE, FLD_MONTH: r = 8'h01;
      FLD_CENT:                      r = 8'h20;
      default:                       r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic bcd8_t field_low(input int unsigned f);
    bcd8_t r;
    case (f)
      FLD_WDAY, FLD_DATE, FLD_MONTH: r = 8'h01;
      default:                       r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic bcd8_t field_high(input int unsigned f);
    bcd8_t r;
    case (f)
      FLD_SEC, FLD_MIN: r = 8'h59;
      FLD_HOUR:         r = 8'h23;
      FLD_WDAY:         r = 8'h07;
      FLD_DATE:         r = 8'h31;
      FLD_MONTH:        r = 8'h12;
      default:          r = 8'h99;
    endcase
    return r;
  endfunction

  // Which field's wrap advances field f.
  function automatic int unsigned carry_src(input int unsigned f);
    int unsigned r;
    case (f)
      FLD_MIN:            r = FLD_SEC;
      FLD_HOUR:           r = FLD_MIN;
      FLD_WDAY, FLD_DATE: r = FLD_HOUR;
      FLD_MONTH:          r = FLD_DATE;
      FLD_YEAR:           r = FLD_MONTH;
      FLD_CENT:           r = FLD_YEAR;
      default:            r = 0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic clear,
  output logic sec_step
);
  localparam int unsigned CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign sec_step = tick_en && run && !clear && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear)           cnt_q <= '0;
    else if (tick_en && run)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R2: the count never passes the last phase of a second
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: stopped and not reloaded means the phase holds
  a_r9_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt_q));

  // R8: a time write restarts the second
  a_r8_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/cal_bcd_stage.sv
`timescale 1ns/1ps
module cal_bcd_stage
  import cal_pkg::*;
(
  input  bcd8_t cur,
  input  bcd8_t low,
  input  bcd8_t high,
  input  logic  inc,
  output bcd8_t nxt,
  output logic  wrap
);
  logic at_top;

  assign at_top = (cur >= high);
  assign wrap   = inc && at_top;

  always_comb begin
    if (!inc)        nxt = cur;
    else if (at_top) nxt = low;
    else             nxt = bcd_inc(cur);
  end
endmodule

// File: rtl/cal_snapshot.sv
`timescale 1ns/1ps
module cal_snapshot #(
  parameter int unsigned N = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [N-1:0][7:0]  live,
  output logic [N-1:0][7:0]  snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap <= '0;
    else if (!hold) snap <= live;
  end

  // R10: a held copy never changes
  a_r10_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(snap));
endmodule

// File: rtl/bcd_calendar_clock.sv
`timescale 1ns/1ps
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data
);
  logic [NUM_FIELDS-1:0][7:0] time_q;
  logic [NUM_FIELDS-1:0][7:0] time_nxt;
  logic [NUM_FIELDS-1:0][7:0] snap;
  logic  run_q, hold_q;
  logic  wr_time, wr_ctrl, sec_step, leap_now;
  bcd8_t date_high;

  assign wr_time   = wr_en && (wr_addr < CTRL_ADDR);
  assign wr_ctrl   = wr_en && (wr_addr == CTRL_ADDR);
  assign leap_now  = is_leap(time_q[FLD_CENT], time_q[FLD_YEAR]);
  assign date_high = month_last_day(time_q[FLD_MONTH], leap_now);

  cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run_q),
    .clear(wr_time), .sec_step(sec_step)
  );

  // One stage per field; each is advanced by the wrap of its carry source.
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int unsigned SRC = carry_src(g);
    logic  inc_i;
    logic  wrap_o;
    bcd8_t high_i;

    if (g == 0) begin : g_head
      assign inc_i = sec_step;
    end else begin : g_chain
      assign inc_i = g_field[SRC].wrap_o;
    end

    if (g == FLD_DATE) begin : g_dyn
      assign high_i = date_high;
    end else begin : g_fix
      assign high_i = field_high(g);
    end

    cal_bcd_stage u_stage (
      .cur(time_q[g]), .low(field_low(g)), .high(high_i),
      .inc(inc_i), .nxt(time_nxt[g]), .wrap(wrap_o)
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_FIELDS; i++) time_q[i] <= field_reset(i);
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (wr_time && (wr_addr[2:0] == 3'(i))) time_q[i] <= wr_data;
        else                                     time_q[i] <= time_nxt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      hold_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q  <= wr_data[0];
      hold_q <= wr_data[1];
    end
  end

  cal_snapshot #(.N(NUM_FIELDS)) u_snap (
    .clk(clk), .rst_n(rst_n), .hold(hold_q), .live(time_q), .snap(snap)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr < CTRL_ADDR)
      rd_data = hold_q ? snap[rd_addr[2:0]] : time_q[rd_addr[2:0]];
    else if (rd_addr == CTRL_ADDR)
      rd_data = {6'd0, hold_q, run_q};
  end

  // R3: seconds roll from 59 to 00
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && time_q[FLD_SEC] == 8'h59) |=> (time_q[FLD_SEC] == 8'h00));

  // R4: day of week returns to 01 after 07
  a_r4_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (g_field[FLD_HOUR].wrap_o && time_q[FLD_WDAY] == 8'h07) |=> (time_q[FLD_WDAY] == 8'h01));

  // R6: leap February reaches the 29th
  a_r6_leap_feb: assert property (@(posedge clk) disable iff (!rst_n)
    (g_field[FLD_HOUR].wrap_o && leap_now && time_q[FLD_MONTH] == 8'h02 &&
     time_q[FLD_DATE] == 8'h28) |=> (time_q[FLD_DATE] == 8'h29));

  // R7: year 99 rolls to 00
  a_r7_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (g_field[FLD_MONTH].wrap_o && time_q[FLD_YEAR] == 8'h99) |=> (time_q[FLD_YEAR] == 8'h00));

  // R8: a written value lands in its register
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> (time_q[$past(wr_addr[2:0])] == $past(wr_data)));

  // R9: stopped counter holds the time
  a_r9_run_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(time_q));
endmodule

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;
  localparam int TPS = 4;

  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0, tick_mode = 0;
  string tag = "R1";
  logic [7:0] dut_regs [16];

  // behavioural reference model (binary integers)
  int m [8];
  int m_snap [8];
  int m_pre;
  bit m_run, m_hold;

  bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] tobcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction
  function automatic int frombcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(int mo, int yr, int ce);
    int full;
    bit leap;
    full = ce * 100 + yr;
    leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] mexp(int a);
    if (a < 8) return m_hold ? tobcd(m_snap[a]) : tobcd(m[a]);
    if (a == 8) return {6'd0, m_hold, m_run};
    return 8'h00;
  endfunction

  task automatic model_reset();
    m = '{0, 0, 0, 1, 1, 1, 0, 20};
    m_snap = '{0, 0, 0, 0, 0, 0, 0, 0};
    m_pre = 0; m_run = 1; m_hold = 0;
  endtask

  task automatic advance();
    m[0]++;
    if (m[0] == 60) begin
      m[0] = 0; m[1]++;
      if (m[1] == 60) begin
        m[1] = 0; m[2]++;
        if (m[2] == 24) begin
          m[2] = 0;
          m[3] = (m[3] == 7) ? 1 : m[3] + 1;
          m[4]++;
          if (m[4] > mdays(m[5], m[6], m[7])) begin
            m[4] = 1; m[5]++;
            if (m[5] == 13) begin
              m[5] = 1; m[6]++;
              if (m[6] == 100) begin
                m[6] = 0; m[7]++;
                if (m[7] == 100) m[7] = 0;
              end
            end
          end
        end
      end
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    bit wt, st;
    if (!rst_n) model_reset();
    else begin
      wt = wr_en && (wr_addr < 8);
      st = tick_en && m_run && (m_pre == TPS - 1) && !wt;
      if (!m_hold) m_snap = m;
      if (wt) m_pre = 0;
      else if (tick_en && m_run) m_pre = (m_pre == TPS - 1) ? 0 : m_pre + 1;
      if (st) advance();
      if (wt) m[wr_addr] = frombcd(wr_data);
      else if (wr_en && wr_addr == 8) begin m_run = wr_data[0]; m_hold = wr_data[1]; end
    end
  end

  // tick_en pattern generator
  always @(posedge clk) begin
    #1;
    case (tick_mode)
      0: tick_en = 1'b0;
      1: tick_en = 1'b1;
      default: tick_en = ($urandom % 3 == 0);
    endcase
  end

  // every cycle: compare all read addresses with the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int a = 0; a < 16; a++) begin
        rd_addr = 4'(a);
        #0.1;
        dut_regs[a] = rd_data;
        checks++;
        if (rd_data !== mexp(a)) begin
          fails++;
          $display("FAIL %s model compare addr %0d actual %h expected %h", tag, a, rd_data, mexp(a));
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic load(input logic [7:0] ce, yr, mo, dt, wd, hr, mi, se);
    wr(7, ce); wr(6, yr); wr(5, mo); wr(4, dt);
    wr(3, wd); wr(2, hr); wr(1, mi); wr(0, se);
  endtask

  task automatic sample();
    @(negedge clk); #3;
  endtask

  task automatic step1();
    repeat (TPS) @(posedge clk);
    sample();
  endtask

  task automatic dchk(int a, logic [7:0] e, string t);
    checks++;
    if (dut_regs[a] !== e) begin
      fails++;
      $display("FAIL %s addr %0d actual %h expected %h", t, a, dut_regs[a], e);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sample();
    tag = "R1";
    dchk(0, 8'h00, "R1 reset seconds"); dchk(1, 8'h00, "R1 reset minutes");
    dchk(2, 8'h00, "R1 reset hours");   dchk(3, 8'h01, "R1 reset weekday");
    dchk(4, 8'h01, "R1 reset date");    dchk(5, 8'h01, "R1 reset month");
    dchk(6, 8'h00, "R1 reset year");    dchk(7, 8'h20, "R1 reset century");
    dchk(8, 8'h01, "R1 reset control");
    for (int a = 9; a < 16; a++) dchk(a, 8'h00, "R11 unmapped read");

    // R2 / R8: prescaler restart timing
    tag = "R2"; tick_mode = 1;
    wr(0, 8'h10);
    repeat (3) @(posedge clk);
    sample(); dchk(0, 8'h10, "R8 no step before a full second");
    sample(); dchk(0, 8'h11, "R2 step on fourth enabled cycle");

    // R8: step coinciding with a time write is dropped
    tag = "R8";
    wr(0, 8'h20);
    repeat (6) @(posedge clk);
    wr(1, 8'h33);
    sample(); dchk(0, 8'h21, "R8 coincident step dropped"); dchk(1, 8'h33, "R8 minutes written");
    repeat (3) @(posedge clk);
    sample(); dchk(0, 8'h21, "R8 restart holds off step");
    sample(); dchk(0, 8'h22, "R8 step a full second after write");

    tag = "R3";
    load(8'h20, 8'h24, 8'h05, 8'h14, 8'h02, 8'h10, 8'h59, 8'h59); step1();
    dchk(0, 8'h00, "R3 seconds wrap"); dchk(1, 8'h00, "R3 minutes wrap"); dchk(2, 8'h11, "R3 hour carry");
    dchk(3, 8'h02, "R4 weekday untouched mid-day");

    tag = "R6";
    load(8'h20, 8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59); step1();
    dchk(4, 8'h29, "R6 leap 2024 date"); dchk(5, 8'h02, "R6 leap 2024 month");
    dchk(3, 8'h01, "R4 weekday 07 to 01"); dchk(2, 8'h00, "R3 hour 23 to 00");
    load(8'h21, 8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); step1();
    dchk(4, 8'h01, "R6 2100 not leap date"); dchk(5, 8'h03, "R6 2100 not leap month");
    dchk(3, 8'h04, "R4 weekday increment");
    load(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); step1();
    dchk(4, 8'h29, "R6 2000 leap");
    load(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59); step1();
    dchk(4, 8'h01, "R6 2023 not leap"); dchk(5, 8'h03, "R6 2023 month");

    tag = "R5";
    load(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59); step1();
    dchk(4, 8'h01, "R5 Feb 29 end"); dchk(5, 8'h03, "R5 Feb to Mar");
    load(8'h20, 8'h24, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59); step1();
    dchk(4, 8'h01, "R5 30-day end"); dchk(5, 8'h05, "R5 Apr to May");
    load(8'h20, 8'h24, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59); step1();
    dchk(4, 8'h31, "R5 31-day month continues"); dchk(5, 8'h01, "R5 month held");

    tag = "R7";
    load(8'h19, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); step1();
    dchk(5, 8'h01, "R7 month wrap"); dchk(6, 8'h00, "R7 year wrap"); dchk(7, 8'h20, "R7 century carry");
    load(8'h99, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); step1();
    dchk(6, 8'h00, "R7 year 99 wrap"); dchk(7, 8'h00, "R7 century 99 wrap"); dchk(4, 8'h01, "R7 date");

    // R9: run bit
    tag = "R9";
    wr(8, 8'h00);
    sample(); v1 = dut_regs[0]; dchk(8, 8'h00, "R9 control readback");
    repeat (20) @(posedge clk);
    sample(); dchk(0, v1, "R9 stopped seconds");
    wr(8, 8'h01);

    // R10: hold snapshot
    tag = "R10";
    wr(0, 8'h10);
    wr(8, 8'h03);
    repeat (12) @(posedge clk);
    sample(); dchk(0, 8'h10, "R10 held seconds"); dchk(8, 8'h03, "R10 control readback");
    wr(8, 8'h01);
    sample(); dchk(0, 8'h14, "R10 live after release");

    // R2: irregular enables against the model, then none
    tag = "R2";
    tick_mode = 2;
    repeat (300) @(posedge clk);
    tick_mode = 0;
    sample(); v1 = dut_regs[0];
    repeat (20) @(posedge clk);
    sample(); dchk(0, v1, "R2 no enables no step");

    finish_run();
  end
endmodule